// File: doc/BRIEF.md
# Asynchronous serial receiver with overrun-protected buffer

This block receives asynchronous serial frames on a single line. The line passes through a two-stage synchronizer. A falling edge starts a candidate frame. The line is sampled again half a bit later, and a high level there is treated as noise, so the receiver goes back to waiting.

When the start is confirmed, the receiver samples 7 or 8 data bits at their bit centres, least significant bit first. Each bit enters the shift register at the top and moves down one place per bit. At the middle of the stop bit the assembled word is committed to a holding register. In the same cycle a buffer-full flag rises and a one-cycle interrupt pulse is issued, and the framing and overrun checks are made.

Bit timing comes from a sampling enable, `tick`, that runs at 16 times the bit rate. A host read strobe returns the held word and clears the buffer-full flag. A word that completes while the holder is still full is dropped, and the old contents are kept.

Top module: `serial_rx_unit`

## Requirements
- R1: After synchronous reset, `rd_data` is 0 and `buf_full`, `rx_irq`, `overrun` and `frame_err` are all 0.
- R2: While `rx_en` is 0, no frame is received. `buf_full` and `rd_data` do not change, and `overrun` and `frame_err` are cleared.
- R3: A falling edge on `rxd` is accepted as a start bit only if the synchronized line is still low on the 8th `tick` after the edge. A low pulse shorter than that produces no word and no interrupt.
- R4: With `len7` = 0, eight data bits are sampled every 16 ticks after the start is accepted. The first bit received becomes bit 0 of `rd_data`.
- R5: With `len7` = 1, seven data bits are received into bits 0 to 6 of `rd_data`, and bit 7 reads 0.
- R6: The stop bit is sampled 16 ticks after the last data bit. In that event the word is loaded, `buf_full` goes to 1 and `rx_irq` is high for exactly one clock.
- R7: A one-cycle `rd_stb` clears `buf_full` to 0 and leaves `rd_data` unchanged.
- R8: If a word completes while `buf_full` is 1 and no read is strobed in that cycle, `overrun` is set, the new word is discarded, `rd_data` keeps its old value and no interrupt is raised.
- R9: A stop bit sampled low sets `frame_err`. The word is still loaded if the buffer is free.
- R10: `overrun` and `frame_err` stay set after a host read. They clear only on an `err_clr` pulse or while `rx_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| tick | input | 1 | Sampling enable at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| rd_stb | input | 1 | Host read strobe, clears buffer-full |
| err_clr | input | 1 | Clears the sticky error flags |
| rd_data | output | 8 | Held receive word |
| buf_full | output | 1 | Holding register contains an unread word |
| rx_irq | output | 1 | One-cycle pulse when a word is loaded |
| overrun | output | 1 | Sticky: a word was dropped because the buffer was full |
| frame_err | output | 1 | Sticky: a stop bit was sampled low |

## Verification
The main path is exercised with several 8-bit values whose bit order is asymmetric: 0xA5, 0x3C and 0x81. Any swap of bit order or an off-by-one in bit count changes the held word. A 7-bit frame of all ones shows that the top bit is forced to zero rather than taken from the stop bit. A 3-tick low glitch separates a real half-bit start check from plain edge triggering. Two unread frames in a row, a frame with a low stop bit and a frame sent while disabled separate the rules for dropping, flagging and clearing.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd,
  output logic rx_s,
  output logic rx_fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-1:0], rxd};
  end

  assign rx_s    = pipe[STAGES-1];
  assign rx_fall = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              short_mode,
  input  logic              tick,
  input  logic              rx_s,
  input  logic              rx_fall,
  output logic              word_valid,
  output logic [DATA_W-1:0] word,
  output logic              stop_bad
);
  localparam int CW   = $clog2(OVS);
  localparam int IDXW = $clog2(DATA_W);
  localparam logic [CW-1:0] HALF_LAST = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(OVS - 1);

  rx_state_t         state;
  logic [CW-1:0]     cnt;
  logic [IDXW-1:0]   idx;
  logic [DATA_W-1:0] sh;
  logic [IDXW-1:0]   last_idx;
  logic [DATA_W-1:0] packed_word;

  assign last_idx = short_mode ? IDXW'(DATA_W - 2) : IDXW'(DATA_W - 1);

  generate
    if (DATA_W > 1) begin : g_pack
      assign packed_word = short_mode ? {1'b0, sh[DATA_W-1:1]} : sh;
    end else begin : g_pack1
      assign packed_word = sh;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      cnt        <= '0;
      idx        <= '0;
      sh         <= '0;
      word       <= '0;
      stop_bad   <= 1'b0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (!en) begin
        state <= RX_IDLE;
      end else begin
        case (state)
          RX_IDLE: begin
            if (rx_fall) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (tick) begin
              if (cnt == HALF_LAST) begin
                cnt <= '0;
                idx <= '0;
                state <= rx_s ? RX_IDLE : RX_DATA;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          RX_DATA: begin
            if (tick) begin
              if (cnt == FULL_LAST) begin
                cnt <= '0;
                sh  <= {rx_s, sh[DATA_W-1:1]};
                idx <= idx + 1'b1;
                if (idx == last_idx) state <= RX_STOP;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          RX_STOP: begin
            if (tick) begin
              if (cnt == FULL_LAST) begin
                cnt        <= '0;
                word       <= packed_word;
                stop_bad   <= ~rx_s;
                word_valid <= 1'b1;
                state      <= RX_IDLE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word,
  input  logic              stop_bad,
  input  logic              rd_stb,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              buf_full,
  output logic              rx_irq,
  output logic              overrun,
  output logic              frame_err
);
  logic load, drop, clr;

  assign load = word_valid & (~buf_full | rd_stb);
  assign drop = word_valid & buf_full & ~rd_stb;
  assign clr  = err_clr | ~en;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      buf_full  <= 1'b0;
      rx_irq    <= 1'b0;
      overrun   <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      rx_irq    <= load;
      overrun   <= (overrun & ~clr) | drop;
      frame_err <= (frame_err & ~clr) | (word_valid & stop_bad);
      if (load) begin
        rd_data  <= word;
        buf_full <= 1'b1;
      end else if (rd_stb) begin
        buf_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              len7,
  input  logic              tick,
  input  logic              rxd,
  input  logic              rd_stb,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              buf_full,
  output logic              rx_irq,
  output logic              overrun,
  output logic              frame_err
);
  logic              rx_s, rx_fall;
  logic              word_valid, stop_bad;
  logic [DATA_W-1:0] word;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rxd(rxd), .rx_s(rx_s), .rx_fall(rx_fall)
  );

  serial_rx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
    .clk(clk), .rst(rst), .en(rx_en), .short_mode(len7), .tick(tick),
    .rx_s(rx_s), .rx_fall(rx_fall), .word_valid(word_valid),
    .word(word), .stop_bad(stop_bad)
  );

  serial_rx_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .en(rx_en), .word_valid(word_valid), .word(word),
    .stop_bad(stop_bad), .rd_stb(rd_stb), .err_clr(err_clr),
    .rd_data(rd_data), .buf_full(buf_full), .rx_irq(rx_irq),
    .overrun(overrun), .frame_err(frame_err)
  );
endmodule

// File: rtl/serial_rx_checks.sv
module serial_rx_checks #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_en,
  input logic              len7,
  input logic              rd_stb,
  input logic              word_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              buf_full,
  input logic              rx_irq,
  input logic              overrun,
  input logic              frame_err
);
  p_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);

  p_irq_full_r6: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> buf_full);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !word_valid) |=> (!buf_full && $stable(rd_data)));

  p_overrun_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (word_valid && buf_full && !rd_stb) |=> (overrun && !rx_irq && $stable(rd_data)));

  p_short_msb_r5: assert property (@(posedge clk) disable iff (rst)
    (word_valid && len7 && (!buf_full || rd_stb)) |=> (rd_data[DATA_W-1] == 1'b0));

  p_disabled_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !word_valid);

  p_flags_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !word_valid) |=> (!overrun && !frame_err));
endmodule

bind serial_rx_unit serial_rx_checks #(.DATA_W(DATA_W)) u_checks (
  .clk(clk), .rst(rst), .rx_en(rx_en), .len7(len7), .rd_stb(rd_stb),
  .word_valid(word_valid), .rd_data(rd_data), .buf_full(buf_full),
  .rx_irq(rx_irq), .overrun(overrun), .frame_err(frame_err)
);

// File: tb/tb_serial_rx_unit.sv
`timescale 1ns/1ps
module tb_serial_rx_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0, len7 = 1'b0, rxd = 1'b1, rd_stb = 1'b0, err_clr = 1'b0;
  logic tick;
  logic [1:0] div = 2'd0;
  logic [7:0] rd_data;
  logic buf_full, rx_irq, overrun, frame_err;

  int checks = 0, errors = 0, irq_cnt = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) div <= div + 2'd1;
  assign tick = (div == 2'd3);

  serial_rx_unit dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .len7(len7), .tick(tick), .rxd(rxd),
    .rd_stb(rd_stb), .err_clr(err_clr), .rd_data(rd_data), .buf_full(buf_full),
    .rx_irq(rx_irq), .overrun(overrun), .frame_err(frame_err)
  );

  // behavioural reference: phase counters in ticks, no structural copy
  int m_s1, m_s2, m_s3, m_state, m_cnt, m_idx, m_sh, m_word;
  int m_buf, m_full, m_irq, m_ovr, m_fe, m_done, m_bad;

  always @(posedge clk) begin
    int load, clr, n_ovr, n_fe, fall, rxb;
    cyc++;
    if (rx_irq) irq_cnt++;
    if (rst) begin
      m_s1 = 1; m_s2 = 1; m_s3 = 1; m_state = 0; m_cnt = 0; m_idx = 0;
      m_sh = 0; m_word = 0; m_buf = 0; m_full = 0; m_irq = 0; m_ovr = 0;
      m_fe = 0; m_done = 0; m_bad = 0;
    end else begin
      load  = (m_done != 0) && (m_full == 0 || rd_stb);
      clr   = err_clr || !rx_en;
      n_ovr = (m_ovr != 0 && !clr) || (m_done != 0 && m_full != 0 && !rd_stb);
      n_fe  = (m_fe != 0 && !clr) || (m_done != 0 && m_bad != 0);
      m_irq = load;
      if (load != 0) begin m_buf = m_word; m_full = 1; end
      else if (rd_stb) m_full = 0;
      m_ovr = n_ovr; m_fe = n_fe;
      fall = (m_s3 == 1 && m_s2 == 0);
      rxb  = m_s2;
      m_done = 0;
      if (!rx_en) m_state = 0;
      else if (m_state == 0) begin
        if (fall != 0) begin m_state = 1; m_cnt = 0; end
      end else if (tick) begin
        m_cnt++;
        if (m_state == 1 && m_cnt == 8) begin
          m_cnt = 0; m_idx = 0;
          m_state = (rxb == 0) ? 2 : 0;
        end else if (m_state == 2 && m_cnt == 16) begin
          m_cnt = 0;
          m_sh = m_sh / 2 + rxb * 128;
          m_idx++;
          if (m_idx == (len7 ? 7 : 8)) m_state = 3;
        end else if (m_state == 3 && m_cnt == 16) begin
          m_cnt = 0; m_done = 1; m_bad = (rxb == 0);
          m_word = len7 ? m_sh / 2 : m_sh;
          m_state = 0;
        end
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = rxd;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("model R4 rd_data", rd_data, m_buf);
      chk("model R6 buf_full", buf_full, m_full);
      chk("model R6 rx_irq", rx_irq, m_irq);
      chk("model R8 overrun", overrun, m_ovr);
      chk("model R9 frame_err", frame_err, m_fe);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(logic [7:0] d, int nb, logic stopv);
    rxd = 1'b0; step(64);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; step(64); end
    rxd = stopv; step(64);
    rxd = 1'b1; step(64);
  endtask

  task automatic host_read();
    rd_stb = 1'b1; step(1); rd_stb = 1'b0; step(2);
  endtask

  initial begin
    int base;
    step(5);
    rst = 1'b0; step(1);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 buf_full", buf_full, 0);
    chk("R1 flags", {rx_irq, overrun, frame_err}, 0);
    rx_en = 1'b1; step(64);

    send(8'hA5, 8, 1'b1);
    chk("R4 word A5", rd_data, 8'hA5);
    chk("R6 buf_full", buf_full, 1);
    chk("R6 one irq", irq_cnt, 1);
    host_read();
    chk("R7 cleared", buf_full, 0);
    chk("R7 data kept", rd_data, 8'hA5);

    send(8'h3C, 8, 1'b1);
    chk("R4 word 3C", rd_data, 8'h3C);
    host_read();

    len7 = 1'b1;
    send(8'hFF, 7, 1'b1);
    chk("R5 seven bits", rd_data, 8'h7F);
    host_read();
    len7 = 1'b0;

    base = irq_cnt;
    rxd = 1'b0; step(12); rxd = 1'b1; step(256);
    chk("R3 glitch no word", buf_full, 0);
    chk("R3 glitch no irq", irq_cnt, base);
    send(8'h81, 8, 1'b1);
    chk("R3 recovery word", rd_data, 8'h81);
    host_read();

    base = irq_cnt;
    send(8'h11, 8, 1'b1);
    send(8'h22, 8, 1'b1);
    chk("R8 overrun set", overrun, 1);
    chk("R8 old kept", rd_data, 8'h11);
    chk("R8 no second irq", irq_cnt, base + 1);
    host_read();
    chk("R10 overrun sticky", overrun, 1);
    err_clr = 1'b1; step(1); err_clr = 1'b0; step(1);
    chk("R10 err_clr", overrun, 0);

    send(8'h66, 8, 1'b0);
    chk("R9 frame_err", frame_err, 1);
    chk("R9 word loaded", rd_data, 8'h66);
    host_read();

    rx_en = 1'b0; step(2);
    chk("R2 flags cleared", frame_err, 0);
    send(8'h99, 8, 1'b1);
    chk("R2 no reception", buf_full, 0);
    chk("R2 data unchanged", rd_data, 8'h66);
    rx_en = 1'b1; step(4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule